// File: doc/BRIEF.md
# TDM Channel Gapped Clock Generator

This block sits on a serial TDM backplane and produces two per-channel timing outputs. It runs on the backplane bit clock, follows a frame sync pulse, and keeps track of which bit of which channel is on the wire in every bit period. From that position and two channel bitmaps it drives a channel-blocking level and a gated copy of the bit clock. The blocking level can gate a downstream serial controller. The gated clock lets a serial or HDLC controller shift only the bits of the channels it owns.

Two frame formats are supported. The 24-channel format has 193 bits per frame: a framing bit leads, then 24 channels of 8 bits. The 32-channel format has 256 bits per frame and no framing bit. Channel bits travel most significant bit first. An optional 56 kbps mode removes the clock pulse from the last (eighth) bit of each channel.

Configuration arrives through a simple byte write port. Every write lands in a shadow copy. The whole shadow copy moves into the working copy only at a frame boundary, so the pattern never changes in the middle of a frame.

Top module: `tdm_gclk_top`

## Requirements
- R1: A frame sync sampled high at a rising clock edge makes the bit period that begins at that edge frame bit 0. Without a sync, the position advances by one bit per clock and wraps to bit 0 after bit 192 (24-channel format) or bit 255 (32-channel format).
- R2: The blocking output is high for all eight bit periods of every channel whose blocking bit is set, and low otherwise. Blocking bytes are written at addresses 0 to 3: address a, data bit i selects channel 8a+i, counted from 0. In the 32-channel format, channel c occupies frame bits 8c to 8c+7.
- R3: Control register address 8, bit 0, selects the format: 1 for 32 channels, 0 for 24 channels. In the 24-channel format, channel c occupies frame bits 1+8c to 8+8c, and bitmap bits for channels 24 to 31 have no effect on either output.
- R4: With the gapped-clock enable set (address 8, bit 1) and a channel selected in the clock bitmap (addresses 4 to 7, same bit order as R2), the gated output gives one clock pulse per bit of that channel. The pulse for a bit is the clock high phase that starts at the rising edge which ends that bit. Unselected channels give no pulses.
- R5: While the gapped-clock enable is clear, the gated clock output stays low.
- R6: With 56 kbps mode set (address 8, bit 2), the eighth bit of each selected channel gets no pulse. The first seven bits still get their pulses.
- R7: In the 24-channel format, during the framing bit the blocking output is low and no gated pulse is produced for it.
- R8: The gated clock output is low whenever the bit clock is low. When it is high, it is high for a full clock high phase, so there are no glitches or runt pulses.
- R9: A write takes effect at the next frame boundary, which is the rising edge where the following bit becomes frame bit 0. A write sampled at that same edge waits for the boundary after it.
- R10: After reset, both outputs are low, all bitmaps and control bits are zero, and the position is frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Backplane bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; high marks frame bit 0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address (0-3 blocking, 4-7 clock map, 8 control) |
| wr_data_i | input | 8 | Register write data |
| chblk_o | output | 1 | Channel-blocking level |
| gclk_o | output | 1 | Gated (gapped) bit clock |

## Verification
Several things can fall on one rising edge: a frame boundary that swaps in the new configuration, a register write, and the gated pulse for the last bit of the previous frame. The bench provokes this collision by sending a control write together with a frame sync, and by letting writes meet the natural wrap of the counter. It then checks two things against its own model. First, the pulse closing the old frame still follows the old settings. Second, the written value waits one more whole frame before it applies. Writes issued mid-frame are judged the same way: outputs must keep the old pattern until the boundary.

// File: rtl/tdm_gclk_pkg.sv
package tdm_gclk_pkg;
  localparam int CH_BITS = 8;
  localparam int MAX_CH  = 32;
  localparam int T1_CH   = 24;
  localparam int DATA_W  = 8;
  localparam int NBYTES  = MAX_CH / DATA_W;
  localparam int E1_LEN  = MAX_CH * CH_BITS;
  localparam int T1_LEN  = T1_CH * CH_BITS + 1;
  localparam int POS_W   = $clog2(E1_LEN);
  localparam int BIT_W   = $clog2(CH_BITS);
  localparam int CH_W    = POS_W - BIT_W;
  localparam int ADDR_W  = $clog2(2 * NBYTES + 1);
  localparam int CTRL_A  = 2 * NBYTES;

  typedef struct packed {
    logic [MAX_CH-1:0] blk;
    logic [MAX_CH-1:0] gap;
    logic              e1;
    logic              gap_en;
    logic              k56;
  } cfg_t;

  typedef struct packed {
    logic             in_ch;
    logic [CH_W-1:0]  ch;
    logic [BIT_W-1:0] bitn;
  } slot_t;

  function automatic logic [POS_W-1:0] last_pos(input logic e1);
    return e1 ? POS_W'(E1_LEN - 1) : POS_W'(T1_LEN - 1);
  endfunction

  function automatic slot_t decode(input logic [POS_W-1:0] pos, input logic e1);
    slot_t s;
    logic [POS_W-1:0] off;
    off     = e1 ? pos : pos - POS_W'(1);
    s.in_ch = e1 || (pos != '0);
    s.ch    = off[POS_W-1:BIT_W];
    s.bitn  = off[BIT_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/tdm_gclk_regs.sv
module tdm_gclk_regs
  import tdm_gclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output cfg_t              act_o
);
  cfg_t sh_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      if (load_i) act_q <= sh_q;
      if (wr_en_i) begin
        for (int k = 0; k < NBYTES; k++) begin
          if (wr_addr_i == ADDR_W'(k))          sh_q.blk[k*DATA_W +: DATA_W] <= wr_data_i;
          if (wr_addr_i == ADDR_W'(NBYTES + k)) sh_q.gap[k*DATA_W +: DATA_W] <= wr_data_i;
        end
        if (wr_addr_i == ADDR_W'(CTRL_A)) begin
          sh_q.e1     <= wr_data_i[0];
          sh_q.gap_en <= wr_data_i[1];
          sh_q.k56    <= wr_data_i[2];
        end
      end
    end
  end

  assign act_o = act_q;

  // R9: working configuration only moves at a frame boundary
  p_hold_midframe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/tdm_gclk_pos.sv
module tdm_gclk_pos
  import tdm_gclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             e1_i,
  output logic [POS_W-1:0] pos_o,
  output logic             load_o
);
  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             at_end;

  assign at_end  = (pos_q == last_pos(e1_i));
  assign pos_nxt = (sync_i || at_end) ? '0 : pos_q + POS_W'(1);
  assign load_o  = (pos_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_nxt;
  end

  assign pos_o = pos_q;

  p_sync_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (pos_q == '0));
  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !at_end) |=> (pos_q == $past(pos_q) + POS_W'(1)));
  p_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_pos(e1_i));
endmodule

// File: rtl/tdm_gclk_gate.sv
module tdm_gclk_gate
  import tdm_gclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  cfg_t             cfg_i,
  output logic             blk_o,
  output logic             gclk_o
);
  slot_t slot;
  logic  last_bit;
  logic  gate_now;
  logic  gate_q;

  assign slot     = decode(pos_i, cfg_i.e1);
  assign last_bit = (slot.bitn == BIT_W'(CH_BITS - 1));
  assign blk_o    = slot.in_ch && cfg_i.blk[slot.ch];
  assign gate_now = cfg_i.gap_en && slot.in_ch && cfg_i.gap[slot.ch]
                    && !(cfg_i.k56 && last_bit);

  // enable changes only in the low phase, so the AND below cannot glitch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_now;
  end

  assign gclk_o = clk_i & gate_q;

  p_gap_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.gap_en |-> !gate_q);
  p_k56_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.k56 && slot.in_ch && last_bit) |-> !gate_q);
  p_frame_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.e1 && pos_i == '0) |-> (!blk_o && !gate_q));
endmodule

// File: rtl/tdm_gclk_top.sv
module tdm_gclk_top
  import tdm_gclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              chblk_o,
  output logic              gclk_o
);
  cfg_t             act;
  logic [POS_W-1:0] pos;
  logic             frame_load;

  tdm_gclk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (frame_load),
    .act_o     (act)
  );

  tdm_gclk_pos u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (fsync_i),
    .e1_i   (act.e1),
    .pos_o  (pos),
    .load_o (frame_load)
  );

  tdm_gclk_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos),
    .cfg_i  (act),
    .blk_o  (chblk_o),
    .gclk_o (gclk_o)
  );
endmodule

// File: tb/sim_tdm_gclk_top.sv
module sim_tdm_gclk_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       chblk, gclk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int mpos = 0;
  bit sb[32], sg[32], se1, sgen, sk56;
  bit ab[32], ag[32], ae1, agen, ak56;
  string tag_blk = "R10";
  string tag_gck = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_gclk_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chblk_o(chblk), .gclk_o(gclk)
  );

  function automatic int chan_of(int p, bit e1);
    if (e1) return p / 8;
    if (p == 0) return -1;
    return (p - 1) / 8;
  endfunction

  function automatic int bit_of(int p, bit e1);
    return e1 ? p % 8 : (p - 1) % 8;
  endfunction

  function automatic bit m_blk();
    int c = chan_of(mpos, ae1);
    return (c >= 0) && ab[c];
  endfunction

  function automatic bit m_gate(output string why);
    int c = chan_of(mpos, ae1);
    why = tag_gck;
    if (c < 0) begin why = "R7"; return 0; end
    if (!agen) begin why = "R5"; return 0; end
    if (ak56 && bit_of(mpos, ae1) == 7) begin why = "R6"; return 0; end
    return ag[c];
  endfunction

  task automatic model_edge(bit s, bit we, int a, int d, output bit eg, output string why);
    int len, nxt;
    eg  = m_gate(why);
    len = ae1 ? 256 : 193;
    nxt = s ? 0 : ((mpos == len - 1) ? 0 : mpos + 1);
    if (nxt == 0) begin
      ab = sb; ag = sg; ae1 = se1; agen = sgen; ak56 = sk56;
    end
    if (we) begin
      if (a < 4)       for (int i = 0; i < 8; i++) sb[a*8+i] = d[i];
      else if (a < 8)  for (int i = 0; i < 8; i++) sg[(a-4)*8+i] = d[i];
      else if (a == 8) begin se1 = d[0]; sgen = d[1]; sk56 = d[2]; end
    end
    mpos = nxt;
  endtask

  task automatic check(logic act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pos %0d: got %b expected %b", tag, what, mpos, act, exp);
    end
  endtask

  task automatic step(bit s, bit we, int a, int d);
    bit eg;
    string why;
    string tb;
    fsync = s; wr_en = we; wr_addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk);
    model_edge(s, we, a, d, eg, why);
    tb = (!ae1 && mpos == 0) ? "R7" : tag_blk;
    #2;
    check(gclk, eg, why, "gated clock high phase");
    check(chblk, m_blk(), tb, "blocking output");
    #5;
    check(gclk, 1'b0, "R8", "gated clock in low phase");
    check(chblk, m_blk(), tb, "blocking output late");
    fsync = 0; wr_en = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    step(0, 1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check(chblk, 1'b0, "R10", "blocking in reset");
      check(gclk, 1'b0, "R10", "gated clock in reset");
    end
    #5 rst_n = 1'b1;
    run(5);

    // R2 / R4: 32-channel format, 64 kbps
    tag_blk = "R2"; tag_gck = "R4";
    wr(0, 8'h81); wr(3, 8'hC0); wr(4, 8'h03); wr(7, 8'h80); wr(8, 3'b011);
    step(1, 0, 0, 0);
    run(600);

    // R9: mid-frame writes wait for the boundary
    tag_blk = "R9"; tag_gck = "R9";
    run(40);
    wr(4, 8'hF0); wr(1, 8'h0F);
    run(400);

    // R3 / R6: 24-channel format, 56 kbps, bits for channels 24-31 set
    tag_blk = "R3"; tag_gck = "R6";
    wr(8, 3'b110); wr(3, 8'hFF); wr(2, 8'h10); wr(6, 8'h81); wr(7, 8'hFF);
    run(500);

    // R1: resync in the middle of a frame
    tag_blk = "R1"; tag_gck = "R1";
    run(50);
    step(1, 0, 0, 0);
    run(120);
    step(1, 0, 0, 0);
    run(250);

    // R5: gapped clock disabled
    tag_blk = "R5"; tag_gck = "R5";
    wr(8, 3'b101);
    run(600);

    // R9: write arriving together with the boundary edge
    tag_blk = "R9"; tag_gck = "R9";
    step(1, 1, 8, 3'b011);
    run(300);
    step(1, 0, 0, 0);
    run(300);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule